// File: doc/BRIEF.md
# Splittable Reload Down-Counter

This block is a timer built from two down-counting halves of equal width, called low and high. Each half has its own preset value, reload strobe, enable and tick input. A count steps down only on a cycle where its enable and its tick are both high. When a count steps down from zero, that half reloads from its preset. Prescaling is done outside the block, so the tick inputs arrive already divided.

In split mode the two halves run on their own. In joined mode the low half borrows into the high half, so the pair forms one counter of twice the width. In joined mode only the low half's enable, tick and reload strobe have any effect.

Two interrupt pulses are produced, each one clock long and registered on the system clock. The primary pulse marks a high-half underflow. The secondary pulse has two sources, chosen by an input. The first is a low-half underflow, which applies in split mode only. The second is a comparator event: it fires once when the count moves to a value at or below a comparator value.

Top module: `split_reload_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `count` is zero and both `irq_pri` and `irq_sec` are low.
- R2: In split mode (`mode16`=0) each half decrements by one on a clock edge where its enable and tick are both high. Otherwise it holds. `count` is laid out as {high half, low half}.
- R3: In split mode, a half that steps from zero loads its own preset in place of the decrement.
- R4: A reload strobe loads that half from its preset on the next edge. It takes priority over a tick in the same cycle.
- R5: In joined mode (`mode16`=1), `lo_en` together with `lo_tick` steps the full count down by one. When the low half steps from zero while the high half is non-zero, the low half becomes all ones and the high half decrements.
- R6: In joined mode, `hi_en`, `hi_tick` and `hi_reload` have no effect on the count.
- R7: In joined mode, `lo_reload` loads {`hi_preset`, `lo_preset`}. The count reloads from those presets only when the full count steps from zero.
- R8: `irq_pri` is high for the one cycle after every edge on which the high half underflows, in both modes. It appears together with the reloaded count.
- R9: With `cmp_mode`=0, `irq_sec` pulses for one cycle after a low-half underflow in split mode. It stays low for low-half underflows in joined mode.
- R10: With `cmp_mode`=1, `irq_sec` pulses for one cycle after the edge on which the count changes from above the comparator to at or below it. Joined mode compares the full count with `cmp_value`. Split mode compares only the upper bytes of the count and of `cmp_value`. The pulse does not repeat while the condition holds, and low-half underflows do not raise `irq_sec` in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode16 | input | 1 | 1 joins the halves into one counter |
| cmp_mode | input | 1 | 1 selects the comparator event as the secondary source |
| lo_en | input | 1 | Low-half enable (full count in joined mode) |
| hi_en | input | 1 | High-half enable (split mode only) |
| lo_tick | input | 1 | Low-half count tick |
| hi_tick | input | 1 | High-half count tick (split mode only) |
| lo_reload | input | 1 | Low-half reload strobe |
| hi_reload | input | 1 | High-half reload strobe (split mode only) |
| lo_preset | input | HALF_W | Low-half preset value |
| hi_preset | input | HALF_W | High-half preset value |
| cmp_value | input | 2*HALF_W | Comparator value |
| irq_pri | output | 1 | High-half underflow pulse |
| irq_sec | output | 1 | Low-half underflow or comparator pulse |
| count | output | 2*HALF_W | Current count, {high, low} |

## Verification
The bench builds the block with HALF_W=4 and HAS_CMP=1. Narrow halves bring a joined-mode borrow, a full underflow and a preset-driven reload within a handful of ticks. Each of these can then be stepped one edge at a time against hand-computed counts. Keeping the comparator variant in place lets the same stimulus table move between split and joined compare. It also shows that the comparator event is edge-like and that compare mode masks low-half underflow.

// File: rtl/srt_pkg.sv
package srt_pkg;

   // Source of the secondary interrupt
   typedef enum logic {
      SEC_UNDERFLOW = 1'b0,
      SEC_COMPARE   = 1'b1
   } sec_sel_e;

endpackage

// File: rtl/srt_half.sv
// One reloadable down-counting half.
module srt_half #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         wrap_max,
   output logic [W-1:0] q,
   output logic [W-1:0] nxt,
   output logic         uflow
);

   always_comb begin
      nxt   = q;
      uflow = 1'b0;
      if (load) begin
         nxt = load_val;
      end else if (step) begin
         if (q == '0) begin
            uflow = 1'b1;
            nxt   = wrap_max ? {W{1'b1}} : load_val;
         end else begin
            nxt = q - {{(W-1){1'b0}}, 1'b1};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/srt_sec.sv
// Secondary interrupt source selection; HAS_CMP picks the variant.
module srt_sec
   import srt_pkg::*;
#(
   parameter int HALF_W  = 8,
   parameter bit HAS_CMP = 1'b1,
   localparam int CNT_W  = 2 * HALF_W
) (
   input  logic             mode16,
   input  sec_sel_e         sel,
   input  logic [CNT_W-1:0] cmp_value,
   input  logic [CNT_W-1:0] cnt_now,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             lo_uflow,
   output logic             sec_d
);

   logic uflow_src;
   assign uflow_src = lo_uflow & ~mode16;

   generate
      if (HAS_CMP) begin : g_cmp
         logic hit_now, hit_nxt;
         always_comb begin
            if (mode16) begin
               hit_now = (cnt_now <= cmp_value);
               hit_nxt = (cnt_nxt <= cmp_value);
            end else begin
               hit_now = (cnt_now[CNT_W-1:HALF_W] <= cmp_value[CNT_W-1:HALF_W]);
               hit_nxt = (cnt_nxt[CNT_W-1:HALF_W] <= cmp_value[CNT_W-1:HALF_W]);
            end
         end
         assign sec_d = (sel == SEC_COMPARE) ? (hit_nxt & ~hit_now) : uflow_src;
      end else begin : g_nocmp
         assign sec_d = uflow_src;
      end
   endgenerate

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
   import srt_pkg::*;
#(
   parameter int HALF_W  = 8,
   parameter bit HAS_CMP = 1'b1,
   localparam int CNT_W  = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode16,
   input  logic              cmp_mode,
   input  logic              lo_en,
   input  logic              hi_en,
   input  logic              lo_tick,
   input  logic              hi_tick,
   input  logic              lo_reload,
   input  logic              hi_reload,
   input  logic [HALF_W-1:0] lo_preset,
   input  logic [HALF_W-1:0] hi_preset,
   input  logic [CNT_W-1:0]  cmp_value,
   output logic              irq_pri,
   output logic              irq_sec,
   output logic [CNT_W-1:0]  count
);

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("split_reload_timer: HALF_W must be at least 2");
      end
   endgenerate

   logic [HALF_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
   logic              lo_uflow, hi_uflow;
   logic              lo_step, hi_step, hi_load, lo_wrap;
   logic              sec_d;
   sec_sel_e          sec_sel;

   assign lo_step = lo_en & lo_tick;
   // joined mode: borrow from low drives high, low strobe drives both
   assign hi_step = mode16 ? lo_uflow  : (hi_en & hi_tick);
   assign hi_load = mode16 ? lo_reload : hi_reload;
   assign lo_wrap = mode16 & (hi_q != '0);
   assign sec_sel = cmp_mode ? SEC_COMPARE : SEC_UNDERFLOW;

   srt_half #(.W(HALF_W)) u_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (lo_reload),
      .load_val (lo_preset),
      .step     (lo_step),
      .wrap_max (lo_wrap),
      .q        (lo_q),
      .nxt      (lo_nxt),
      .uflow    (lo_uflow)
   );

   srt_half #(.W(HALF_W)) u_hi (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hi_load),
      .load_val (hi_preset),
      .step     (hi_step),
      .wrap_max (1'b0),
      .q        (hi_q),
      .nxt      (hi_nxt),
      .uflow    (hi_uflow)
   );

   srt_sec #(.HALF_W(HALF_W), .HAS_CMP(HAS_CMP)) u_sec (
      .mode16    (mode16),
      .sel       (sec_sel),
      .cmp_value (cmp_value),
      .cnt_now   ({hi_q, lo_q}),
      .cnt_nxt   ({hi_nxt, lo_nxt}),
      .lo_uflow  (lo_uflow),
      .sec_d     (sec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pri <= 1'b0;
         irq_sec <= 1'b0;
      end else begin
         irq_pri <= hi_uflow;
         irq_sec <= sec_d;
      end
   end

   assign count = {hi_q, lo_q};

endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
   parameter int HALF_W  = 8,
   parameter bit HAS_CMP = 1'b1,
   localparam int CNT_W  = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode16,
   input logic              cmp_mode,
   input logic              hi_en,
   input logic              lo_tick,
   input logic              lo_reload,
   input logic              hi_reload,
   input logic [HALF_W-1:0] lo_preset,
   input logic [HALF_W-1:0] hi_preset,
   input logic [CNT_W-1:0]  cmp_value,
   input logic              irq_pri,
   input logic              irq_sec,
   input logic [CNT_W-1:0]  count
);

   // R8
   pri_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pri |-> (count[CNT_W-1:HALF_W] == $past(hi_preset)));

   // R9
   sec_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sec && (!HAS_CMP || !$past(cmp_mode))) |->
         (!$past(mode16) && count[HALF_W-1:0] == $past(lo_preset)));

   // R10
   sec_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sec && HAS_CMP && $past(cmp_mode)) |->
         ($past(mode16) ? (count <= $past(cmp_value))
                        : (count[CNT_W-1:HALF_W] <= $past(cmp_value[CNT_W-1:HALF_W]))));

   // R6
   joined_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode16 && !lo_tick && !lo_reload) |=> $stable(count));

   // R2
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode16 && !hi_en && !hi_reload) |=> $stable(count[CNT_W-1:HALF_W]));

   // R4
   lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode16 && lo_reload) |=> (count[HALF_W-1:0] == $past(lo_preset)));

endmodule

bind split_reload_timer srt_chk #(.HALF_W(HALF_W), .HAS_CMP(HAS_CMP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode16    (mode16),
   .cmp_mode  (cmp_mode),
   .hi_en     (hi_en),
   .lo_tick   (lo_tick),
   .lo_reload (lo_reload),
   .hi_reload (hi_reload),
   .lo_preset (lo_preset),
   .hi_preset (hi_preset),
   .cmp_value (cmp_value),
   .irq_pri   (irq_pri),
   .irq_sec   (irq_sec),
   .count     (count)
);

// File: tb/split_reload_timer_tb.sv
`timescale 1ns/1ps
module split_reload_timer_tb;

   localparam int HW = 4;
   localparam int CW = 2 * HW;
   localparam int NV = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode16 = 0, cmp_mode = 0, lo_en = 0, hi_en = 0;
   logic          lo_tick = 0, hi_tick = 0, lo_reload = 0, hi_reload = 0;
   logic [HW-1:0] lo_preset = '0, hi_preset = '0;
   logic [CW-1:0] cmp_value = '0;
   logic          irq_pri, irq_sec;
   logic [CW-1:0] count;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   split_reload_timer #(.HALF_W(HW), .HAS_CMP(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode16(mode16), .cmp_mode(cmp_mode),
      .lo_en(lo_en), .hi_en(hi_en), .lo_tick(lo_tick), .hi_tick(hi_tick),
      .lo_reload(lo_reload), .hi_reload(hi_reload),
      .lo_preset(lo_preset), .hi_preset(hi_preset), .cmp_value(cmp_value),
      .irq_pri(irq_pri), .irq_sec(irq_sec), .count(count)
   );

   // ctrl {mode16,cmp_mode,lo_en,hi_en,lo_tick,hi_tick,lo_reload,hi_reload},
   // lo_preset, hi_preset, cmp_value, expected count, expected irq_pri, irq_sec
   localparam logic [33:0] VECS [NV] = '{
      {8'b00000011, 4'h3, 4'h2, 8'h00, 8'h23, 1'b0, 1'b0}, // R4 load both
      {8'b00111100, 4'h3, 4'h2, 8'h00, 8'h12, 1'b0, 1'b0}, // R2
      {8'b00111100, 4'h3, 4'h2, 8'h00, 8'h01, 1'b0, 1'b0}, // R2
      {8'b00111100, 4'h3, 4'h2, 8'h00, 8'h20, 1'b1, 1'b0}, // R3 R8 high uflow
      {8'b00101000, 4'h3, 4'h2, 8'h00, 8'h23, 1'b0, 1'b1}, // R3 R9 low uflow
      {8'b00001100, 4'h3, 4'h2, 8'h00, 8'h23, 1'b0, 1'b0}, // R2 no enables
      {8'b00101110, 4'h9, 4'h2, 8'h00, 8'h29, 1'b0, 1'b0}, // R4 strobe beats tick
      {8'b10101001, 4'h9, 4'h5, 8'h00, 8'h28, 1'b0, 1'b0}, // R6 hi strobe ignored
      {8'b10000010, 4'h1, 4'h0, 8'h00, 8'h01, 1'b0, 1'b0}, // R7 joined load
      {8'b10101000, 4'h1, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0}, // R5
      {8'b10101000, 4'h1, 4'h0, 8'h00, 8'h01, 1'b1, 1'b0}, // R7 R8 R9 full uflow
      {8'b10000010, 4'h0, 4'h1, 8'h00, 8'h10, 1'b0, 1'b0}, // R7
      {8'b10101000, 4'h0, 4'h1, 8'h00, 8'h0F, 1'b0, 1'b0}, // R5 borrow
      {8'b10010100, 4'h0, 4'h1, 8'h00, 8'h0F, 1'b0, 1'b0}, // R6 hi tick ignored
      {8'b11101000, 4'h0, 4'h1, 8'h0E, 8'h0E, 1'b0, 1'b1}, // R10 joined compare
      {8'b11101000, 4'h0, 4'h1, 8'h0E, 8'h0D, 1'b0, 1'b0}, // R10 no repeat
      {8'b01000011, 4'h0, 4'h3, 8'h2F, 8'h30, 1'b0, 1'b0}, // R10 above compare
      {8'b01010100, 4'h0, 4'h3, 8'h2F, 8'h20, 1'b0, 1'b1}, // R10 upper byte only
      {8'b01101000, 4'h0, 4'h3, 8'h2F, 8'h20, 1'b0, 1'b0}  // R10 uflow masked
   };

   task automatic check(input string req, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1", "count in reset", count, '0);
      check("R1", "irq_pri in reset", {7'd0, irq_pri}, '0);
      check("R1", "irq_sec in reset", {7'd0, irq_sec}, '0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "count after release", count, '0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {mode16, cmp_mode, lo_en, hi_en, lo_tick, hi_tick, lo_reload, hi_reload} = VECS[i][33:26];
         lo_preset = VECS[i][25:22];
         hi_preset = VECS[i][21:18];
         cmp_value = VECS[i][17:10];
         @(posedge clk); #1;
         check("R2-table", "count", count, VECS[i][9:2]);
         check("R8", "irq_pri", {7'd0, irq_pri}, {7'd0, VECS[i][1]});
         check(VECS[i][33] ? "R9/R10 joined" : "R9/R10 split", "irq_sec",
               {7'd0, irq_sec}, {7'd0, VECS[i][0]});
      end

      // R3 preset zero: consecutive underflows each pulse (split mode)
      @(negedge clk);
      {mode16, cmp_mode, lo_en, hi_en, lo_tick, hi_tick, lo_reload, hi_reload} = 8'b00000001;
      hi_preset = 4'h0;
      @(posedge clk); #1;
      check("R4", "hi load zero", count, 8'h00);
      @(negedge clk);
      {mode16, cmp_mode, lo_en, hi_en, lo_tick, hi_tick, lo_reload, hi_reload} = 8'b00010100;
      @(posedge clk); #1;
      check("R3", "hi reload zero", count, 8'h00);
      check("R8", "irq_pri first", {7'd0, irq_pri}, 8'h01);
      @(posedge clk); #1;
      check("R8", "irq_pri second", {7'd0, irq_pri}, 8'h01);

      // R1 mid-run reset
      @(negedge clk);
      hi_preset = 4'h7;
      {mode16, cmp_mode, lo_en, hi_en, lo_tick, hi_tick, lo_reload, hi_reload} = 8'b00000011;
      @(posedge clk); #1;
      check("R4", "hi load seven", count, 8'h70);
      rst_n = 1'b0;
      #1;
      check("R1", "count after reset", count, '0);
      check("R1", "irq_pri after reset", {7'd0, irq_pri}, '0);
      finish_run();
   end

endmodule